// File: doc/BRIEF.md
# Snooping Coherence Bus Sequencer

This block is the shared-bus controller of a snoopy multiprocessor memory system. Four agents raise requests, each with a command and a line address. The sequencer grants the bus to one agent at a time, in round-robin order. It then broadcasts the command and address to all snoopers and samples their per-agent copy and dirty responses. From those responses it decides how the transaction completes:

- A memory read.
- A cache-to-cache transfer, where the memory read is cancelled.
- A combined transfer and write-back.
- An aborted read-with-intent-to-modify (RWITM). In this case the dirty owner writes back first and the requester is told to retry.

A requester learns three things from its response: whether another copy of the line survives, whether it must retry, and the fill data. Snooping caches update their own line states from the broadcast command. The sequencer only steers data.

The controller is a single state machine with these states:

- `ST_IDLE`: waiting for a request.
- `ST_ADDR`: address phase.
- `ST_SNOOP`: snoop window.
- `ST_MEMRD`: memory data.
- `ST_XFER`: cache supplies the data.
- `ST_WBACK`: dirty owner writes back.
- `ST_DONE`: response.

Its transitions are:

- Grant: `ST_IDLE` to `ST_ADDR`.
- Broadcast: `ST_ADDR` to `ST_SNOOP`.
- Invalidate finish: `ST_SNOOP` to `ST_DONE`.
- Memory fetch: `ST_SNOOP` to `ST_MEMRD`.
- Intervention: `ST_SNOOP` to `ST_XFER`.
- Abort: `ST_SNOOP` to `ST_WBACK`.
- `ST_MEMRD`, `ST_XFER` and `ST_WBACK` each move to `ST_DONE`.
- Release: `ST_DONE` to `ST_IDLE`.

Top module: `snoop_bus_seq`

## Requirements
- R1: At most one bit of `gnt` is high. Once granted, `gnt` stays unchanged until and including the cycle in which `rsp_valid` is high, and it drops in the following cycle.
- R2: Arbitration is round-robin. After reset, agent 0 has top priority. After a completed (non-retried) response, priority passes to the agent after the owner, modulo four.
- R3: When a response carries `rsp_retry`, the round-robin position is not advanced. If the same agent still requests, it wins the next grant over every other requester.
- R4: `bus_valid` is high for exactly one cycle per transaction, in the first cycle `gnt` is high. In that cycle `bus_cmd` and `bus_addr` carry the owner's request. Command encoding: 2'b01 is memory read, 2'b10 is RWITM, 2'b11 is invalidate, and 2'b00 is treated as a read.
- R5: `snp_hit` (copy held in E, S or M) and `snp_mod` (copy held in M) are sampled in the cycle after `bus_valid`. The requester's own bits are ignored.
- R6: A read with no copy among the other agents issues one `mem_re` and returns `mem_rdata` with `rsp_shared`=0. `rsp_valid` is high in the fourth cycle after the request is first seen in `ST_IDLE`.
- R7: A read that hits a clean copy in other agents does not assert `mem_re` or `mem_we`. The lowest-numbered hitting agent is selected on `sup_sel`, and its `snp_data` is returned with `rsp_shared`=1, in the same four-cycle latency.
- R8: A read that finds another agent with a modified copy selects that agent ahead of clean holders. Its data is returned with `rsp_shared`=1 and is written to memory (`mem_we`, `mem_addr` equal to the line address) within the same transaction, without `mem_re`.
- R9: RWITM with no modified copy elsewhere reads memory and returns `mem_rdata` with `rsp_shared`=0 and `rsp_retry`=0, without `mem_we`.
- R10: RWITM that finds a modified copy elsewhere asserts no `mem_re`. It writes the owner's data to memory and ends with `rsp_retry`=1 in the fourth cycle.
- R11: Invalidate performs no memory access. `rsp_valid` is high in the third cycle after the request is seen, which is the cycle after the snoop window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-agent bus request, held until the response |
| req_cmd | input | 2*N | Per-agent command, 2 bits per agent |
| req_addr | input | N*AW | Per-agent line address |
| gnt | output | N | One-hot bus ownership |
| bus_valid | output | 1 | Address-phase strobe to snoopers |
| bus_cmd | output | 2 | Broadcast command |
| bus_addr | output | AW | Broadcast line address |
| snp_hit | input | N | Per-agent "holds a valid copy" response |
| snp_mod | input | N | Per-agent "holds the copy modified" response |
| snp_data | input | N*DW | Per-agent line data, driven when selected |
| sup_sel | output | N | One-hot selection of the agent driving data |
| mem_re | output | 1 | Memory read strobe; data expected next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| rsp_valid | output | 1 | Response to the owner, one cycle |
| rsp_shared | output | 1 | Another cache keeps a copy |
| rsp_retry | output | 1 | RWITM aborted; reissue |
| rsp_data | output | DW | Fill data |

## Verification
Two events can fall in the same cycle: the cache-to-cache transfer to the requester and the write-back of a modified line to memory. Both happen in `ST_XFER` when a read finds a dirty copy. The sweep provokes this by marking one of the other agents modified for every requester and every hit pattern. It judges the cycle by checking that `rsp_data` and the single observed memory write both equal that agent's data, and that no memory read occurred. The second coincidence is retry against a competing request. The bench holds two requests at once, forces an abort, and checks that the aborted agent regains the bus before the waiting one.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_RWITM = 2'b10,
        CMD_INV   = 2'b11
    } bus_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SNOOP,
        ST_MEMRD,
        ST_XFER,
        ST_WBACK,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/sbs_rr_arb.sv
module sbs_rr_arb #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last_idx,
    output logic          any,
    output logic [IW-1:0] win_idx
);
    // nearest agent after last_idx wins; farther candidates are overwritten
    always_comb begin
        int idx;
        any     = 1'b0;
        win_idx = '0;
        for (int k = N; k >= 1; k--) begin
            idx = (int'(last_idx) + k) % N;
            if (req[idx]) begin
                any     = 1'b1;
                win_idx = idx[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/sbs_snoop_resolve.sv
module sbs_snoop_resolve #(
    parameter int N = 4
) (
    input  logic [N-1:0] hit,
    input  logic [N-1:0] mod,
    input  logic [N-1:0] own,
    output logic         any_hit,
    output logic         any_mod,
    output logic [N-1:0] sup
);
    logic [N-1:0] eh, em, eh_lo, em_lo;

    always_comb begin
        eh      = (hit | mod) & ~own;
        em      = mod & ~own;
        eh_lo   = eh & (~eh + {{(N-1){1'b0}}, 1'b1});
        em_lo   = em & (~em + {{(N-1){1'b0}}, 1'b1});
        any_hit = |eh;
        any_mod = |em;
        sup     = any_mod ? em_lo : eh_lo;
    end
endmodule

// File: rtl/snoop_bus_seq.sv
module snoop_bus_seq
    import sbs_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [2*N-1:0]  req_cmd,
    input  logic [N*AW-1:0] req_addr,
    output logic [N-1:0]    gnt,
    output logic            bus_valid,
    output logic [1:0]      bus_cmd,
    output logic [AW-1:0]   bus_addr,
    input  logic [N-1:0]    snp_hit,
    input  logic [N-1:0]    snp_mod,
    input  logic [N*DW-1:0] snp_data,
    output logic [N-1:0]    sup_sel,
    output logic            mem_re,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            rsp_valid,
    output logic            rsp_shared,
    output logic            rsp_retry,
    output logic [DW-1:0]   rsp_data
);
    localparam int IW = $clog2(N);

    seq_state_e    state;
    logic [IW-1:0] owner, last;
    bus_cmd_e      cmd_q;
    logic [AW-1:0] addr_q;
    logic [N-1:0]  sup_q;
    logic          mod_q, shared_q, retry_q;
    logic [DW-1:0] data_q;

    logic          arb_any;
    logic [IW-1:0] arb_idx;
    logic [N-1:0]  own_oh, res_sup;
    logic          res_hit, res_mod;
    logic          need_mem;
    logic [DW-1:0] sup_data;

    assign own_oh = {{(N-1){1'b0}}, 1'b1} << owner;

    sbs_rr_arb #(.N(N), .IW(IW)) u_arb (
        .req     (req),
        .last_idx(last),
        .any     (arb_any),
        .win_idx (arb_idx)
    );

    sbs_snoop_resolve #(.N(N)) u_res (
        .hit    (snp_hit),
        .mod    (snp_mod),
        .own    (own_oh),
        .any_hit(res_hit),
        .any_mod(res_mod),
        .sup    (res_sup)
    );

    always_comb begin
        sup_data = '0;
        for (int i = 0; i < N; i++) begin
            if (sup_q[i]) sup_data = sup_data | snp_data[i*DW +: DW];
        end
    end

    // memory is needed unless the snoop window found a cache to supply
    always_comb begin
        unique case (cmd_q)
            CMD_INV:   need_mem = 1'b0;
            CMD_RWITM: need_mem = !res_mod;
            default:   need_mem = !res_hit;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            owner    <= '0;
            last     <= IW'(N - 1);
            cmd_q    <= CMD_NONE;
            addr_q   <= '0;
            sup_q    <= '0;
            mod_q    <= 1'b0;
            shared_q <= 1'b0;
            retry_q  <= 1'b0;
            data_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (arb_any) begin
                        owner  <= arb_idx;
                        cmd_q  <= bus_cmd_e'(req_cmd[arb_idx*2 +: 2]);
                        addr_q <= req_addr[arb_idx*AW +: AW];
                        state  <= ST_ADDR;
                    end
                end
                ST_ADDR: state <= ST_SNOOP;
                ST_SNOOP: begin
                    shared_q <= 1'b0;
                    retry_q  <= 1'b0;
                    mod_q    <= res_mod;
                    if (cmd_q == CMD_INV) begin
                        state <= ST_DONE;
                    end else if (need_mem) begin
                        state <= ST_MEMRD;
                    end else begin
                        sup_q <= res_sup;
                        state <= (cmd_q == CMD_RWITM) ? ST_WBACK : ST_XFER;
                    end
                end
                ST_MEMRD: begin
                    data_q <= mem_rdata;
                    state  <= ST_DONE;
                end
                ST_XFER: begin
                    data_q   <= sup_data;
                    shared_q <= 1'b1;
                    sup_q    <= '0;
                    state    <= ST_DONE;
                end
                ST_WBACK: begin
                    retry_q <= 1'b1;
                    sup_q   <= '0;
                    state   <= ST_DONE;
                end
                ST_DONE: begin
                    if (!retry_q) last <= owner;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        gnt        = (state != ST_IDLE) ? own_oh : '0;
        bus_valid  = (state == ST_ADDR);
        bus_cmd    = cmd_q;
        bus_addr   = addr_q;
        sup_sel    = sup_q;
        mem_addr   = addr_q;
        mem_re     = (state == ST_SNOOP) && need_mem;
        mem_we     = (state == ST_WBACK) || ((state == ST_XFER) && mod_q);
        mem_wdata  = sup_data;
        rsp_valid  = (state == ST_DONE);
        rsp_shared = shared_q;
        rsp_retry  = retry_q;
        rsp_data   = data_q;
    end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] gnt,
    input logic         bus_valid,
    input logic [1:0]   bus_cmd,
    input logic [N-1:0] sup_sel,
    input logic         mem_re,
    input logic         mem_we,
    input logic         rsp_valid,
    input logic         rsp_retry
);
    a_r1_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r1_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && !rsp_valid) |=> $stable(gnt));

    a_r4_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt) |-> bus_valid);

    a_r7_mem_cancelled: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sup_sel == '0) && !mem_we);

    a_r8_write_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $onehot(sup_sel));

    a_r10_retry_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_retry) |-> $past(mem_we));

    a_r11_inv_short: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_cmd == 2'b11)) |=> ##1 (rsp_valid && !mem_we));
endmodule

bind snoop_bus_seq sbs_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt      (gnt),
    .bus_valid(bus_valid),
    .bus_cmd  (bus_cmd),
    .sup_sel  (sup_sel),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .rsp_valid(rsp_valid),
    .rsp_retry(rsp_retry)
);

// File: tb/tb_snoop_bus_seq.sv
module tb_snoop_bus_seq;
    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [2*N-1:0]  req_cmd = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N-1:0]    gnt;
    logic            bus_valid;
    logic [1:0]      bus_cmd;
    logic [AW-1:0]   bus_addr;
    logic [N-1:0]    snp_hit = '0;
    logic [N-1:0]    snp_mod = '0;
    logic [N*DW-1:0] snp_data = '0;
    logic [N-1:0]    sup_sel;
    logic            mem_re, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata = '0;
    logic            rsp_valid, rsp_shared, rsp_retry;
    logic [DW-1:0]   rsp_data;

    always #5 clk = ~clk;

    snoop_bus_seq #(.N(N), .AW(AW), .DW(DW)) dut (.*);

    int n_chk = 0;
    int n_err = 0;
    int rd_cnt = 0, wr_cnt = 0, bv_cnt = 0;
    logic [DW-1:0] wr_data_l;
    logic [AW-1:0] wr_addr_l, bv_addr_l;
    logic [1:0]    bv_cmd_l;

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return {16'hD00D, a};
    endfunction

    function automatic logic [DW-1:0] snp_val(input int i, input logic [AW-1:0] a);
        return {4'hC, 4'(i), 8'h5A, a};
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) if (v[i]) lowest = i;
        if (v == '0) lowest = -1;
    endfunction

    // memory and bus observer
    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= mem_val(mem_addr);
            rd_cnt = rd_cnt + 1;
        end
        if (mem_we) begin
            wr_cnt = wr_cnt + 1;
            wr_data_l = mem_wdata;
            wr_addr_l = mem_addr;
        end
        if (bus_valid) begin
            bv_cnt = bv_cnt + 1;
            bv_cmd_l = bus_cmd;
            bv_addr_l = bus_addr;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_rsp(output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rsp_valid && lat < 40);
    endtask

    task automatic run_txn(input int ag, input logic [1:0] c, input logic [N-1:0] hit,
                           input logic [N-1:0] mod, input logic [AW-1:0] a);
        int lat, rd0, wr0, bv0, exp_lat, exp_rd, exp_wr, sup;
        logic [N-1:0] own, eh, em;
        logic exp_sh, exp_rt;
        logic [DW-1:0] exp_d;
        logic chk_d;
        @(negedge clk);
        req_cmd[ag*2 +: 2] = c;
        req_addr[ag*AW +: AW] = a;
        snp_hit = hit;
        snp_mod = mod;
        for (int i = 0; i < N; i++) snp_data[i*DW +: DW] = snp_val(i, a);
        rd0 = rd_cnt; wr0 = wr_cnt; bv0 = bv_cnt;
        req[ag] = 1'b1;
        wait_rsp(lat);
        own = N'(1) << ag;
        eh = (hit | mod) & ~own;
        em = mod & ~own;
        exp_lat = 4; exp_rd = 0; exp_wr = 0; exp_sh = 0; exp_rt = 0;
        exp_d = mem_val(a); chk_d = 1'b1; sup = -1;
        if (c == 2'b11) begin
            exp_lat = 3; chk_d = 1'b0;
        end else if (c == 2'b10) begin
            if (em != '0) begin
                exp_rt = 1; exp_wr = 1; sup = lowest(em); chk_d = 1'b0;
            end else exp_rd = 1;
        end else begin
            if (em != '0) begin
                sup = lowest(em); exp_wr = 1; exp_sh = 1; exp_d = snp_val(sup, a);
            end else if (eh != '0) begin
                sup = lowest(eh); exp_sh = 1; exp_d = snp_val(sup, a);
            end else exp_rd = 1;
        end
        chk("R1 gnt at response", gnt, own);
        chk("R4 one address phase", bv_cnt - bv0, 1);
        chk("R4 bus_cmd", bv_cmd_l, c);
        chk("R4 bus_addr", bv_addr_l, a);
        if (c == 2'b11) begin
            chk("R11 latency", lat, exp_lat);
            chk("R11 no mem read", rd_cnt - rd0, 0);
            chk("R11 no mem write", wr_cnt - wr0, 0);
        end else if (c == 2'b10) begin
            chk(em != '0 ? "R10 latency" : "R9 latency", lat, exp_lat);
            chk(em != '0 ? "R10 mem reads" : "R9 mem reads", rd_cnt - rd0, exp_rd);
            chk(em != '0 ? "R10 mem writes" : "R9 mem writes", wr_cnt - wr0, exp_wr);
            chk(em != '0 ? "R10 retry" : "R9 retry", rsp_retry, exp_rt);
            if (em != '0) chk("R10 writeback data", wr_data_l, snp_val(sup, a));
            else chk("R9 shared", rsp_shared, 0);
        end else begin
            chk("R6 R7 R8 latency", lat, exp_lat);
            chk(em != '0 ? "R8 mem reads" : (eh != '0 ? "R7 mem reads" : "R6 mem reads"),
                rd_cnt - rd0, exp_rd);
            chk(em != '0 ? "R8 mem writes" : "R7 R6 mem writes", wr_cnt - wr0, exp_wr);
            chk(em != '0 ? "R8 shared" : (eh != '0 ? "R7 shared" : "R6 shared"),
                rsp_shared, exp_sh);
            chk("R5 R7 retry clear", rsp_retry, 0);
            if (em != '0) begin
                chk("R8 writeback data", wr_data_l, snp_val(sup, a));
                chk("R8 writeback addr", wr_addr_l, a);
            end
        end
        if (chk_d) chk("R5 R6 R7 R8 R9 data", rsp_data, exp_d);
        req[ag] = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end

    initial begin
        int lat;
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        chk("R1 reset gnt", gnt, 0);
        chk("R4 reset bus_valid", bus_valid, 0);
        chk("R6 reset mem strobes", {mem_re, mem_we}, 0);
        chk("R1 reset rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;

        // R2: all four request at once, reads with no copies
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            req_cmd[i*2 +: 2] = 2'b01;
            req_addr[i*AW +: AW] = AW'(16'h0100 + i);
        end
        req = '1;
        for (int k = 0; k < N; k++) begin
            wait_rsp(lat);
            chk("R2 round-robin order", gnt, N'(1) << k);
            chk("R2 data", rsp_data, mem_val(AW'(16'h0100 + k)));
            req[k] = 1'b0;
        end
        @(negedge clk);
        chk("R1 grant released", gnt, 0);

        // sweep: requester x command x snoop pattern
        a = 16'h1000;
        for (int ag = 0; ag < N; ag++) begin
            for (int ci = 1; ci <= 3; ci++) begin
                for (int h = 0; h < 16; h++) begin
                    run_txn(ag, 2'(ci), 4'(h), 4'b0000, a);
                    a = a + 16'h0013;
                    for (int m = 0; m < N; m++) begin
                        if (h[m]) begin
                            run_txn(ag, 2'(ci), 4'(h), 4'(1 << m), a);
                            a = a + 16'h0013;
                        end
                    end
                end
            end
        end
        run_txn(2, 2'b00, 4'b0000, 4'b0000, 16'h7777);  // R4 2'b00 acts as read

        // R3: retry keeps the aborted agent ahead of a waiting one
        run_txn(0, 2'b01, 4'b0000, 4'b0000, 16'h2000);  // owner 0 -> agent 1 next
        @(negedge clk);
        req_cmd[1*2 +: 2] = 2'b10;  req_addr[1*AW +: AW] = 16'h3000;
        req_cmd[3*2 +: 2] = 2'b01;  req_addr[3*AW +: AW] = 16'h3100;
        snp_hit = 4'b0100; snp_mod = 4'b0100;
        for (int i = 0; i < N; i++) snp_data[i*DW +: DW] = snp_val(i, 16'h3000);
        req = 4'b1010;
        wait_rsp(lat);
        chk("R3 first owner", gnt, 4'b0010);
        chk("R3 R10 retry", rsp_retry, 1);
        snp_hit = '0; snp_mod = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 reissue wins", gnt, 4'b0010);
        wait_rsp(lat);
        chk("R3 R9 reissued data", rsp_data, mem_val(16'h3000));
        chk("R3 R9 no retry", rsp_retry, 0);
        req[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 R3 waiting agent next", gnt, 4'b1000);
        wait_rsp(lat);
        chk("R6 waiting agent data", rsp_data, mem_val(16'h3100));
        req[3] = 1'b0;
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule